// File: doc/BRIEF.md
# Pin Port with Peripheral Direction Takeover

This block is one eight-pin slice of a general-purpose I/O port that hangs on a simple byte-wide register bus. It has two registers. The pin-sample register is read-only. It returns the pad levels after a two-flop synchronizer. The pin-direction register is read/write and sets, bit by bit, whether each pin drives or floats.

Two serial peripherals can take a pin away from software. A synchronous serial interface owns the pins in its mask and supplies both their direction and their drive value. An asynchronous serial channel has a transmit mask and a receive mask. Its transmit pins are forced to drive and its receive pins are forced to float. The takeover priority is the synchronous interface first, then asynchronous transmit, then asynchronous receive, then the software direction bit.

When a peripheral releases a pin, the stored direction bit controls that pin again. Software does not need to rewrite it. The pin-sample register reads the pads even on driven pins, so software can compare the level it drives with the level it reads back and detect a shorted or overloaded pin.

Top module: `pinctl_port`

## Requirements
- R1: After reset the pin-direction register reads 0x00 and every output enable is 0.
- R2: A bus write to address BASE_ADDR+1 loads the pin-direction register, and the new value reads back from the cycle after the write.
- R3: A bus write to BASE_ADDR (the pin-sample register) has no effect: the direction register, the output enables and the sampled value are all unchanged.
- R4: A read at BASE_ADDR returns the pad levels with two clocks of latency. A pad change is not visible after one rising edge and is visible after the second.
- R5: The pin-sample register shows the pad level on pins that are driven as outputs, including a level opposite to the driven value.
- R6: On a pin that no peripheral owns, direction bit 1 gives output enable 1 with drive from `gpio_dout`, and direction bit 0 gives output enable 0.
- R7: With `sync_en`=1, every pin in `sync_mask` takes its enable from `sync_dir` and its drive from `sync_dout`, whatever the other inputs are.
- R8: With `atx_en`=1, every pin in `atx_mask` that the synchronous interface does not own has output enable 1 and drive from `atx_dout`.
- R9: With `arx_en`=1, every pin in `arx_mask` that neither the synchronous interface nor asynchronous transmit owns has output enable 0.
- R10: When a peripheral is disabled, its pins return to the stored direction bits without any register write.
- R11: Any address other than BASE_ADDR and BASE_ADDR+1 reads 0x00, and writes to such an address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (4) | Byte address |
| bus_wdata | input | WIDTH (8) | Write data |
| bus_rdata | output | WIDTH (8) | Read data (combinational, 0 when not selected) |
| pad_in | input | WIDTH (8) | Pad input levels |
| gpio_dout | input | WIDTH (8) | Software drive values |
| sync_en | input | 1 | Synchronous serial interface enable |
| sync_mask | input | WIDTH (8) | Pins owned by the synchronous interface |
| sync_dir | input | WIDTH (8) | Direction requested by the synchronous interface |
| sync_dout | input | WIDTH (8) | Drive values from the synchronous interface |
| atx_en | input | 1 | Asynchronous transmit enable |
| atx_mask | input | WIDTH (8) | Pins owned by asynchronous transmit |
| atx_dout | input | WIDTH (8) | Drive values from asynchronous transmit |
| arx_en | input | 1 | Asynchronous receive enable |
| arx_mask | input | WIDTH (8) | Pins owned by asynchronous receive |
| pin_oe | output | WIDTH (8) | Per-pin output enable |
| pin_dout | output | WIDTH (8) | Per-pin drive value |

## Verification
The bench tests every combination of the three peripheral enables against several overlapping mask patterns and direction values. A design that gets the priority wrong lets transmit or the direction bit override the synchronous interface on shared pins. The bench also checks the exact edge at which a pad change reaches a read. A design with one synchronizer stage too many or too few shows the new value one clock too late or too early. A write to the read-only address, a write to an unmapped address and a peripheral release are each checked at the ports. The short test drives a pin high, pulls its pad low, and expects the low level to read back. It catches a design that returns the driven value instead of the pad.

// File: rtl/pinctl_pkg.sv
package pinctl_pkg;

  // Per-pin direction decision, in priority order.
  function automatic logic pick_dir(input logic s_own, input logic s_dir,
                                    input logic t_own, input logic r_own,
                                    input logic sw_dir);
    logic d;
    if (s_own)      d = s_dir;
    else if (t_own) d = 1'b1;
    else if (r_own) d = 1'b0;
    else            d = sw_dir;
    return d;
  endfunction

  // Per-pin drive value; a floating pin still carries the software value.
  function automatic logic pick_drive(input logic s_own, input logic s_val,
                                      input logic t_own, input logic t_val,
                                      input logic sw_val);
    logic v;
    if (s_own)      v = s_val;
    else if (t_own) v = t_val;
    else            v = sw_val;
    return v;
  endfunction

endpackage

// File: rtl/pinctl_sync.sv
module pinctl_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pad_i,
  output logic [WIDTH-1:0] pad_s
);
  localparam int CW = $clog2(STAGES + 1);

  logic [WIDTH-1:0] stage_q [STAGES];
  logic [CW-1:0]    settle_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else if (g == 0) stage_q[g] <= pad_i;
        else stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) settle_q <= '0;
    else if (settle_q != CW'(STAGES)) settle_q <= settle_q + 1'b1;
  end

  assign pad_s = stage_q[STAGES-1];

  AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (settle_q == CW'(STAGES)) |-> (pad_s == $past(pad_i, 2))); // R4

endmodule

// File: rtl/pinctl_regs.sv
module pinctl_regs #(
  parameter int          WIDTH     = 8,
  parameter int          ADDR_W    = 4,
  parameter logic [3:0]  BASE_ADDR = 4'h2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pad_s,
  output logic [WIDTH-1:0]  dir_q
);
  localparam logic [ADDR_W-1:0] SAMPLE_A = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] DIR_A    = ADDR_W'(BASE_ADDR + 1);

  logic hit_sample, hit_dir, dir_load;

  assign hit_sample = bus_sel && (bus_addr == SAMPLE_A);
  assign hit_dir    = bus_sel && (bus_addr == DIR_A);
  assign dir_load   = hit_dir && bus_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        dir_q <= '0;
    else if (dir_load) dir_q <= bus_wdata;
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_sample)   bus_rdata = pad_s;
    else if (hit_dir) bus_rdata = dir_q;
  end

  AST_DIR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    dir_load |=> (dir_q == $past(bus_wdata))); // R2
  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_load |=> $stable(dir_q)); // R3
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_sample && !hit_dir) |-> (bus_rdata == '0)); // R11

endmodule

// File: rtl/pinctl_arb.sv
module pinctl_arb #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] gpio_dout,
  input  logic             sync_en,
  input  logic [WIDTH-1:0] sync_mask,
  input  logic [WIDTH-1:0] sync_dir,
  input  logic [WIDTH-1:0] sync_dout,
  input  logic             atx_en,
  input  logic [WIDTH-1:0] atx_mask,
  input  logic [WIDTH-1:0] atx_dout,
  input  logic             arx_en,
  input  logic [WIDTH-1:0] arx_mask,
  output logic [WIDTH-1:0] pin_oe,
  output logic [WIDTH-1:0] pin_dout
);
  import pinctl_pkg::*;

  logic [WIDTH-1:0] sync_own, tx_own, rx_own, free_pin;

  assign sync_own = sync_en ? sync_mask : '0;
  assign tx_own   = atx_en  ? atx_mask  : '0;
  assign rx_own   = arx_en  ? arx_mask  : '0;
  assign free_pin = ~(sync_own | tx_own | rx_own);

  genvar g;
  generate
    for (g = 0; g < WIDTH; g++) begin : g_pin
      assign pin_oe[g]   = pick_dir(sync_own[g], sync_dir[g], tx_own[g],
                                    rx_own[g], dir_q[g]);
      assign pin_dout[g] = pick_drive(sync_own[g], sync_dout[g], tx_own[g],
                                      atx_dout[g], gpio_dout[g]);
    end
  endgenerate

  AST_SYNC_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_oe ^ sync_dir) & sync_own) == '0); // R7
  AST_TX_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    ((tx_own & ~sync_own) & ~pin_oe) == '0); // R8
  AST_RX_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
    ((rx_own & ~tx_own & ~sync_own) & pin_oe) == '0); // R9
  AST_FREE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_oe ^ dir_q) & free_pin) == '0); // R6

endmodule

// File: rtl/pinctl_port.sv
module pinctl_port #(
  parameter int         WIDTH     = 8,
  parameter int         ADDR_W    = 4,
  parameter logic [3:0] BASE_ADDR = 4'h2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pad_in,
  input  logic [WIDTH-1:0]  gpio_dout,
  input  logic              sync_en,
  input  logic [WIDTH-1:0]  sync_mask,
  input  logic [WIDTH-1:0]  sync_dir,
  input  logic [WIDTH-1:0]  sync_dout,
  input  logic              atx_en,
  input  logic [WIDTH-1:0]  atx_mask,
  input  logic [WIDTH-1:0]  atx_dout,
  input  logic              arx_en,
  input  logic [WIDTH-1:0]  arx_mask,
  output logic [WIDTH-1:0]  pin_oe,
  output logic [WIDTH-1:0]  pin_dout
);
  logic [WIDTH-1:0] pad_s;
  logic [WIDTH-1:0] dir_q;

  pinctl_sync #(.WIDTH(WIDTH), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .pad_i(pad_in), .pad_s(pad_s)
  );

  pinctl_regs #(.WIDTH(WIDTH), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_s(pad_s), .dir_q(dir_q)
  );

  pinctl_arb #(.WIDTH(WIDTH)) u_arb (
    .clk(clk), .rst_n(rst_n), .dir_q(dir_q), .gpio_dout(gpio_dout),
    .sync_en(sync_en), .sync_mask(sync_mask), .sync_dir(sync_dir),
    .sync_dout(sync_dout), .atx_en(atx_en), .atx_mask(atx_mask),
    .atx_dout(atx_dout), .arx_en(arx_en), .arx_mask(arx_mask),
    .pin_oe(pin_oe), .pin_dout(pin_dout)
  );

  AST_RESET_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (dir_q == '0)); // R1
  AST_RELEASE_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_en && !atx_en && !arx_en) |-> (pin_oe == dir_q)); // R10

endmodule

// File: tb/pinctl_port_test.sv
module pinctl_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam logic [3:0] BASE = 4'h2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [W-1:0] bus_wdata = '0, bus_rdata;
  logic [W-1:0] pad_in = '0, gpio_dout = 8'hC3;
  logic sync_en = 1'b0, atx_en = 1'b0, arx_en = 1'b0;
  logic [W-1:0] sync_mask = '0, sync_dir = 8'h66, sync_dout = 8'h5A;
  logic [W-1:0] atx_mask = '0, atx_dout = 8'hF0, arx_mask = '0;
  logic [W-1:0] pin_oe, pin_dout;

  int vectors = 0, miscompares = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pinctl_port uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .gpio_dout(gpio_dout), .sync_en(sync_en),
    .sync_mask(sync_mask), .sync_dir(sync_dir), .sync_dout(sync_dout),
    .atx_en(atx_en), .atx_mask(atx_mask), .atx_dout(atx_dout),
    .arx_en(arx_en), .arx_mask(arx_mask), .pin_oe(pin_oe), .pin_dout(pin_dout)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [W-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [W-1:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  // Independent vector-wide model of the takeover priority.
  task automatic expect_pins(input logic [W-1:0] dir, output logic [W-1:0] oe,
                             output logic [W-1:0] dv);
    logic [W-1:0] s, t, r;
    s = {W{sync_en}} & sync_mask;
    t = {W{atx_en}} & atx_mask & ~s;
    r = {W{arx_en}} & arx_mask & ~s & ~t;
    oe = (s & sync_dir) | t | (dir & ~(s | t | r));
    dv = (s & sync_dout) | (t & atx_dout) | (gpio_dout & ~(s | t));
  endtask

  initial begin
    logic [W-1:0] rd, eoe, edv;
    logic [W-1:0] dirs [4];
    dirs[0] = 8'h00; dirs[1] = 8'hFF; dirs[2] = 8'hA5; dirs[3] = 8'h3C;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 oe", pin_oe, 8'h00);
    bus_read(BASE + 4'd1, rd); check("R1 dir", rd, 8'h00);

    // R4: two-clock sampling latency
    pad_in = 8'h96; repeat (3) @(negedge clk);
    bus_read(BASE, rd); check("R4 settled", rd, 8'h96);
    pad_in = 8'h69; @(negedge clk);
    bus_read(BASE, rd); check("R4 one edge", rd, 8'h96);
    @(negedge clk);
    bus_read(BASE, rd); check("R4 two edges", rd, 8'h69);

    // R3: write to read-only sample register
    bus_write(BASE, 8'hFF);
    bus_read(BASE + 4'd1, rd); check("R3 dir", rd, 8'h00);
    check("R3 oe", pin_oe, 8'h00);
    bus_read(BASE, rd); check("R3 sample", rd, 8'h69);

    // R11: unmapped address
    bus_write(BASE + 4'd2, 8'hFF);
    bus_read(BASE + 4'd1, rd); check("R11 dir", rd, 8'h00);
    bus_read(BASE + 4'd2, rd); check("R11 read", rd, 8'h00);
    bus_read(4'h0, rd); check("R11 read0", rd, 8'h00);

    // R2, R6-R9: sweep directions x enables x mask patterns
    for (int d = 0; d < 4; d++) begin
      bus_write(BASE + 4'd1, dirs[d]);
      bus_read(BASE + 4'd1, rd); check("R2 dir", rd, dirs[d]);
      for (int p = 0; p < 3; p++) begin
        case (p)
          0: begin sync_mask = 8'h0F; atx_mask = 8'h3C; arx_mask = 8'hF0; end
          1: begin sync_mask = 8'h81; atx_mask = 8'h03; arx_mask = 8'h07; end
          default: begin sync_mask = 8'h00; atx_mask = 8'h18; arx_mask = 8'h66; end
        endcase
        for (int e = 0; e < 8; e++) begin
          @(negedge clk);
          sync_en = e[0]; atx_en = e[1]; arx_en = e[2];
          #1 expect_pins(dirs[d], eoe, edv);
          check("R6-R9 oe (R7 R8 R9 R6)", pin_oe, eoe);
          check("R6 R7 R8 drive", pin_dout, edv);
        end
      end
    end

    // R10: release restores stored direction
    bus_write(BASE + 4'd1, 8'hA5);
    @(negedge clk); sync_en = 1; atx_en = 1; arx_en = 1;
    sync_mask = 8'hFF; #1 check("R7 full takeover", pin_oe, sync_dir);
    @(negedge clk); sync_en = 0; atx_en = 0; arx_en = 0;
    #1 check("R10 release oe", pin_oe, 8'hA5);
    check("R10 release drive", pin_dout, gpio_dout);

    // R5: short on a driven pin reads back the pad level
    bus_write(BASE + 4'd1, 8'hFF);
    pad_in = gpio_dout ^ 8'h01; repeat (3) @(negedge clk);
    check("R5 still driving", pin_oe, 8'hFF);
    bus_read(BASE, rd); check("R5 short readback", rd, 8'hC2);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule